// File: doc/BRIEF.md
# Configurable GPIO Port Register Block

This block is a sixteen-pin general-purpose I/O port. Its settings sit in a bank of 32-bit registers on a simple word-addressed bus. Each pin has its own fields for mode, driver type, drive speed, pull resistor and alternate-function number. Together these fields decide what the pad-side output, output-enable and pull-control signals do for that pin.

The pad inputs pass through a synchronizer before software can read them. Software can write the output data word whole. It can also change single output bits atomically through a set/clear register.

Each pin can take its output from one of several peripheral sources, picked by its alternate-function number. The driver-type field turns a pin into an open-drain output, which only ever pulls low.

Top module: `gpio_port`

## Requirements
- R1: After reset, every readable register reads 0. All `pad_oe`, `pad_pull_up` and `pad_pull_dn` bits are 0, so every pin is an input with no pull.
- R2: The mode (word 0), speed (word 2) and pull (word 3) registers read back as written. Pin n uses bits [2n+1:2n] in each. The speed word appears unchanged on `pad_speed`.
- R3: Writing the output data register (word 5) loads its low 16 bits and ignores the upper 16. Mode code 01 (output) drives `pad_out`[n] from data bit n and sets `pad_oe`[n], starting the cycle after the write.
- R4: The set/clear register (word 6) reads as 0. On a write, a 1 in bit n (n<16) sets data bit n and a 1 in bit n+16 clears it. When both are 1, the bit is set. Bits with neither are unchanged.
- R5: Driver-type register (word 1) bit n equal to 1 makes pin n open-drain. An active open-drain pin asserts `pad_oe`[n] only while its driven value is 0. With bit n equal to 0, an active pin always asserts `pad_oe`[n].
- R6: Mode code 10 (alternate) drives `pad_out`[n] from `alt_src`[16n+s], and `pad_oe`[n] is set as for an output. The selector s is 4 bits. For pins 0-7 it is in word 8 at bits [4n+3:4n]. For pins 8-15 it is in word 9 at bits [4(n-8)+3:4(n-8)]. Both words read back as written.
- R7: The input data register (word 4) returns the pad levels in bits [15:0]. A level change shows there after two rising clock edges and not after one. A pin in mode code 11 (analog) reads 0.
- R8: Pull code 01 asserts `pad_pull_up`[n]. Code 10 asserts `pad_pull_dn`[n]. Codes 00 and 11 assert neither. A pin in analog mode asserts neither.
- R9: Mode codes 00 (input) and 11 (analog) never assert `pad_oe`[n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word index |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word, combinational |
| pad_in | input | 16 | Raw pad input levels |
| pad_out | output | 16 | Output level for each pad |
| pad_oe | output | 16 | Output-driver enable for each pad |
| pad_pull_up | output | 16 | Pull-up enable for each pad |
| pad_pull_dn | output | 16 | Pull-down enable for each pad |
| pad_speed | output | 32 | Two drive-speed bits per pad |
| alt_src | input | 256 | Peripheral outputs; pin n, source s at bit 16n+s |

## Verification
Reads are combinational, so a register read is compared in the same cycle the address is presented. Anything that depends on a write is compared one rising edge after the write strobe: the register value, `pad_out`, `pad_oe`, the pull signals and `pad_speed`. A pad input change is compared twice, once after one rising edge (old value still expected) and once after two (new value expected), which pins the synchronizer depth exactly. The driver applies each stimulus on a falling edge and queues the expected value. The monitor compares a short delay after that same falling edge, so no comparison lands on an active edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int NPINS    = 16;
    localparam int DW       = 32;
    localparam int AW       = 4;
    localparam int AFW      = 4;
    localparam int FLD2     = 2;

    typedef enum logic [1:0] {
        MODE_IN     = 2'b00,
        MODE_OUT    = 2'b01,
        MODE_ALT    = 2'b10,
        MODE_ANALOG = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        PULL_NONE = 2'b00,
        PULL_UP   = 2'b01,
        PULL_DOWN = 2'b10,
        PULL_RSVD = 2'b11
    } pull_e;

    // word offsets; order is fixed by software
    localparam logic [AW-1:0] W_MODE  = 4'd0;
    localparam logic [AW-1:0] W_OTYPE = 4'd1;
    localparam logic [AW-1:0] W_SPEED = 4'd2;
    localparam logic [AW-1:0] W_PULL  = 4'd3;
    localparam logic [AW-1:0] W_IDATA = 4'd4;
    localparam logic [AW-1:0] W_ODATA = 4'd5;
    localparam logic [AW-1:0] W_SETCL = 4'd6;
    localparam logic [AW-1:0] W_LOCK  = 4'd7;
    localparam logic [AW-1:0] W_AFLO  = 4'd8;
    localparam logic [AW-1:0] W_AFHI  = 4'd9;

    typedef struct packed {
        pin_mode_e       mode;
        logic            od;
        logic [1:0]      speed;
        pull_e           pull;
        logic [AFW-1:0]  afsel;
    } pin_cfg_t;

    function automatic logic drives_pad(pin_mode_e m);
        return (m == MODE_OUT) || (m == MODE_ALT);
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [AW-1:0]       bus_addr,
    input  logic                bus_we,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic [NPINS-1:0]    idata,
    output pin_cfg_t            cfg [NPINS],
    output logic [NPINS-1:0]    odata,
    output logic [DW-1:0]       speed_word
);
    localparam int HALF = NPINS / 2;

    logic [DW-1:0]    mode_q, speed_q, pull_q, aflo_q, afhi_q;
    logic [NPINS-1:0] otype_q, odata_q;
    logic [NPINS-1:0] set_bits, clr_bits;

    assign set_bits = bus_wdata[NPINS-1:0];
    assign clr_bits = bus_wdata[DW-1:NPINS];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            speed_q <= '0;
            pull_q  <= '0;
            aflo_q  <= '0;
            afhi_q  <= '0;
            otype_q <= '0;
            odata_q <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                W_MODE:  mode_q  <= bus_wdata;
                W_OTYPE: otype_q <= bus_wdata[NPINS-1:0];
                W_SPEED: speed_q <= bus_wdata;
                W_PULL:  pull_q  <= bus_wdata;
                W_ODATA: odata_q <= bus_wdata[NPINS-1:0];
                W_SETCL: odata_q <= (odata_q & ~clr_bits) | set_bits;
                W_AFLO:  aflo_q  <= bus_wdata;
                W_AFHI:  afhi_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            W_MODE:  bus_rdata = mode_q;
            W_OTYPE: bus_rdata = {{(DW-NPINS){1'b0}}, otype_q};
            W_SPEED: bus_rdata = speed_q;
            W_PULL:  bus_rdata = pull_q;
            W_IDATA: bus_rdata = {{(DW-NPINS){1'b0}}, idata};
            W_ODATA: bus_rdata = {{(DW-NPINS){1'b0}}, odata_q};
            W_AFLO:  bus_rdata = aflo_q;
            W_AFHI:  bus_rdata = afhi_q;
            default: bus_rdata = '0;
        endcase
    end

    for (genvar n = 0; n < NPINS; n++) begin : g_cfg
        assign cfg[n].mode  = pin_mode_e'(mode_q[FLD2*n +: FLD2]);
        assign cfg[n].od    = otype_q[n];
        assign cfg[n].speed = speed_q[FLD2*n +: FLD2];
        assign cfg[n].pull  = pull_e'(pull_q[FLD2*n +: FLD2]);
        if (n < HALF) begin : g_lo
            assign cfg[n].afsel = aflo_q[AFW*n +: AFW];
        end else begin : g_hi
            assign cfg[n].afsel = afhi_q[AFW*(n-HALF) +: AFW];
        end
    end

    assign odata      = odata_q;
    assign speed_word = speed_q;

    // R3: a whole-word data write lands exactly
    a_r3_odata_load: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == W_ODATA) |=> (odata == $past(bus_wdata[NPINS-1:0])));

    // R4: requested set bits end up 1 (set wins)
    a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == W_SETCL) |=>
            ((odata & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

    // R4: clear-only bits end up 0
    a_r4_clear_only: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == W_SETCL) |=>
            ((odata & $past(bus_wdata[DW-1:NPINS] & ~bus_wdata[NPINS-1:0])) == '0));

    // R4: the set/clear word never reads back
    a_r4_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == W_SETCL) |-> (bus_rdata == '0));
endmodule

// File: rtl/gpio_pin.sv
module gpio_pin
    import gpio_pkg::*;
#(
    parameter int NALT = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  pin_cfg_t        cfg,
    input  logic            odata_bit,
    input  logic [NALT-1:0] alt_bits,
    input  logic            pad_sync,
    output logic            pad_out,
    output logic            pad_oe,
    output logic            pull_up,
    output logic            pull_dn,
    output logic            idata_bit
);
    logic alt_val, drive_val, active, analog;

    always_comb begin
        alt_val = 1'b0;
        if (int'(cfg.afsel) < NALT) alt_val = alt_bits[cfg.afsel];
    end

    assign analog    = (cfg.mode == MODE_ANALOG);
    assign active    = drives_pad(cfg.mode);
    assign drive_val = (cfg.mode == MODE_ALT) ? alt_val : odata_bit;

    assign pad_out   = drive_val;
    assign pad_oe    = active && (!cfg.od || !drive_val);
    assign pull_up   = !analog && (cfg.pull == PULL_UP);
    assign pull_dn   = !analog && (cfg.pull == PULL_DOWN);
    assign idata_bit = pad_sync && !analog;

    // R5: an open-drain pin never drives high
    a_r5_od_release: assert property (@(posedge clk) disable iff (rst)
        (cfg.od && pad_out) |-> !pad_oe);

    // R9: input and analog pins keep the driver off
    a_r9_idle_no_drive: assert property (@(posedge clk) disable iff (rst)
        (cfg.mode == MODE_IN || cfg.mode == MODE_ANALOG) |-> !pad_oe);

    // R8: never both pulls at once
    a_r8_pull_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(pull_up && pull_dn));

    // R7: an analog pin reads 0
    a_r7_analog_zero: assert property (@(posedge clk) disable iff (rst)
        analog |-> !idata_bit);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int NALT        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [AW-1:0]           bus_addr,
    input  logic                    bus_we,
    input  logic [DW-1:0]           bus_wdata,
    output logic [DW-1:0]           bus_rdata,
    input  logic [NPINS-1:0]        pad_in,
    output logic [NPINS-1:0]        pad_out,
    output logic [NPINS-1:0]        pad_oe,
    output logic [NPINS-1:0]        pad_pull_up,
    output logic [NPINS-1:0]        pad_pull_dn,
    output logic [DW-1:0]           pad_speed,
    input  logic [NPINS*NALT-1:0]   alt_src
);
    pin_cfg_t         cfg [NPINS];
    logic [NPINS-1:0] odata, pad_sync, idata;

    gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pad_sync)
    );

    gpio_regs i_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .idata      (idata),
        .cfg        (cfg),
        .odata      (odata),
        .speed_word (pad_speed)
    );

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        gpio_pin #(.NALT(NALT)) i_pin (
            .clk       (clk),
            .rst       (rst),
            .cfg       (cfg[n]),
            .odata_bit (odata[n]),
            .alt_bits  (alt_src[NALT*n +: NALT]),
            .pad_sync  (pad_sync[n]),
            .pad_out   (pad_out[n]),
            .pad_oe    (pad_oe[n]),
            .pull_up   (pad_pull_up[n]),
            .pull_dn   (pad_pull_dn[n]),
            .idata_bit (idata[n])
        );
    end
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
    localparam int P_RDATA = 0, P_OUT = 1, P_OE = 2, P_PU = 3, P_PD = 4, P_SPD = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [15:0]  pad_in = '0;
    logic [15:0]  pad_out, pad_oe, pad_pull_up, pad_pull_dn;
    logic [31:0]  pad_speed;
    logic [255:0] alt_src = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int          probe;
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    gpio_port i_gpio_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_up(pad_pull_up),
        .pad_pull_dn(pad_pull_dn), .pad_speed(pad_speed), .alt_src(alt_src)
    );

    // monitor: compares queued expectations shortly after each falling edge
    always begin
        @(negedge clk);
        #1;
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.probe)
                P_RDATA: act = bus_rdata;
                P_OUT:   act = {16'h0, pad_out};
                P_OE:    act = {16'h0, pad_oe};
                P_PU:    act = {16'h0, pad_pull_up};
                P_PD:    act = {16'h0, pad_pull_dn};
                default: act = pad_speed;
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s probe %0d actual %h expected %h", it.req, it.probe, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic chk(input int probe, input logic [3:0] a, input logic [31:0] e, input string r);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        it.probe = probe; it.exp = e; it.req = r;
        sb.push_back(it);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(P_RDATA, 4'd0, 32'h0, "R1 mode");
        chk(P_RDATA, 4'd1, 32'h0, "R1 otype");
        chk(P_RDATA, 4'd2, 32'h0, "R1 speed");
        chk(P_RDATA, 4'd3, 32'h0, "R1 pull");
        chk(P_RDATA, 4'd5, 32'h0, "R1 odata");
        chk(P_RDATA, 4'd8, 32'h0, "R1 aflo");
        chk(P_RDATA, 4'd9, 32'h0, "R1 afhi");
        chk(P_OE, 4'd0, 32'h0, "R1 oe");
        chk(P_PU, 4'd0, 32'h0, "R1 pull up");
        chk(P_PD, 4'd0, 32'h0, "R1 pull down");

        // R3 outputs on pins 1,2
        wr(4'd0, 32'h0000_0014);
        chk(P_RDATA, 4'd0, 32'h0000_0014, "R2 mode readback");
        wr(4'd5, 32'hFFFF_0006);
        chk(P_RDATA, 4'd5, 32'h0000_0006, "R3 odata upper ignored");
        chk(P_OUT, 4'd0, 32'h0000_0006, "R3 pad_out");
        chk(P_OE, 4'd0, 32'h0000_0006, "R3 pad_oe");

        // R4 set/clear
        wr(4'd6, 32'h0002_0001);
        chk(P_RDATA, 4'd5, 32'h0000_0005, "R4 set and clear");
        chk(P_RDATA, 4'd6, 32'h0, "R4 reads zero");
        wr(4'd6, 32'h0008_0008);
        chk(P_RDATA, 4'd5, 32'h0000_000D, "R4 set wins");

        // R5 open drain on pin 2
        wr(4'd1, 32'h0000_0004);
        chk(P_RDATA, 4'd1, 32'h0000_0004, "R5 otype readback");
        chk(P_OE, 4'd0, 32'h0000_0002, "R5 od high released");
        wr(4'd6, 32'h0004_0000);
        chk(P_OE, 4'd0, 32'h0000_0006, "R5 od low driven");

        // R6 alternate function on pin 9, selector in high word
        alt_src[9*16+5] = 1'b1;
        wr(4'd0, 32'h0008_0014);
        wr(4'd9, 32'h0000_0050);
        chk(P_RDATA, 4'd9, 32'h0000_0050, "R6 afhi readback");
        chk(P_OUT, 4'd0, 32'h0000_0209, "R6 alt source 5");
        chk(P_OE, 4'd0, 32'h0000_0206, "R6 alt oe");
        @(negedge clk);
        alt_src[9*16+5] = 1'b0;
        alt_src[9*16+6] = 1'b1;
        chk(P_OUT, 4'd0, 32'h0000_0009, "R6 source 5 low");
        wr(4'd9, 32'h0000_0060);
        chk(P_OUT, 4'd0, 32'h0000_0209, "R6 alt source 6");
        wr(4'd8, 32'h0000_00A0);
        chk(P_RDATA, 4'd8, 32'h0000_00A0, "R6 aflo readback");

        // R2 speed, R8 pulls
        wr(4'd2, 32'hC000_0003);
        chk(P_RDATA, 4'd2, 32'hC000_0003, "R2 speed readback");
        chk(P_SPD, 4'd0, 32'hC000_0003, "R2 pad_speed");
        wr(4'd3, 32'h0000_0039);
        chk(P_RDATA, 4'd3, 32'h0000_0039, "R2 pull readback");
        chk(P_PU, 4'd0, 32'h0000_0001, "R8 pull up");
        chk(P_PD, 4'd0, 32'h0000_0002, "R8 pull down");

        // R7 synchronizer latency
        @(negedge clk);
        pad_in = 16'hA5A5;
        chk(P_RDATA, 4'd4, 32'h0000_0000, "R7 one edge old");
        chk(P_RDATA, 4'd4, 32'h0000_A5A5, "R7 two edges new");

        // R7/R8/R9 analog on pin 0
        wr(4'd0, 32'h0008_0017);
        chk(P_RDATA, 4'd4, 32'h0000_A5A4, "R7 analog reads zero");
        chk(P_PU, 4'd0, 32'h0000_0000, "R8 analog no pull");
        chk(P_OE, 4'd0, 32'h0000_0206, "R9 analog no oe");
        wr(4'd0, 32'h0008_0013);
        chk(P_OE, 4'd0, 32'h0000_0204, "R9 input no oe");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule